// File: doc/BRIEF.md
# Compressed-Mode Branch Target Unit

This block sits beside the fetch stage of a core that runs a 16-bit compressed instruction encoding. Each cycle it looks at the current instruction and its address. It recognises four kinds of control transfer: a short branch gated by a condition, a medium-range unconditional jump, a subroutine call split over two halves, and a jump through a register that may also switch instruction sets. For every instruction it produces the next fetch address, whether a branch is taken, any write to the link register, and the instruction-set mode to fetch in next. The whole path is combinational, so the result is valid in the same cycle as the inputs.

A long call is made of two separate instructions. The first half places a partial target in the link register, so an interrupt may arrive between the halves without losing state. The second half adds its low offset to that partial target, jumps, and stores the return address. Every return address the block writes has bit 0 set, which marks the caller as compressed code. For register jumps, bit 0 of the register value picks the target instruction set.

Top module: `branch_target_unit`

## Requirements
- R1: Conditional short branch (bits 15:12 = 1101, condition in 11:8, signed 8-bit offset in 7:0). When its condition holds, takenOut = 1 and targetAddr = insnAddr + 4 + (sign-extended offset × 2). No link write occurs.
- R2: Condition codes are evaluated from the flags as follows. 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R3: A conditional branch whose condition fails gives takenOut = 0, targetAddr = insnAddr + 2 and linkWrEn = 0.
- R4: Unconditional branch (bits 15:11 = 11100, signed 11-bit offset in 10:0). It is always taken, with targetAddr = insnAddr + 4 + (sign-extended offset × 2), computed modulo 2^32.
- R5: Long call, first half (bits 15:11 = 11110, offset in 10:0). takenOut = 0, targetAddr = insnAddr + 2, linkWrEn = 1 and linkWrData = insnAddr + 4 + (sign-extended offset << 12).
- R6: Long call, second half (bits 15:11 = 11111, unsigned offset in 10:0). takenOut = 1 and targetAddr = (linkValue + offset × 2) with bit 0 cleared. linkWrEn = 1 and linkWrData = (insnAddr + 2) | 1. Chained with the first half, this reaches ±4 MB around the first half's address + 4.
- R7: Register jump (bits 15:7 = 010001110, register index in 6:3, bits 2:0 = 000). rmSel = bits 6:3 and takenOut = 1. If rmValue bit 0 is 1, modeOut = 1 and targetAddr = rmValue with bit 0 cleared. If it is 0, modeOut = 0 and targetAddr = rmValue with bits 1:0 cleared. No link write occurs.
- R8: Register jump with link (bits 15:7 = 010001111, otherwise as R7). It selects the target and mode as in R7, and also sets linkWrEn = 1 with linkWrData = (insnAddr + 2) | 1.
- R9: Condition codes 1110 and 1111 in the conditional format are not branches: takenOut = 0, targetAddr = insnAddr + 2, no link write. Code 1111 alone raises swiOut.
- R10: Any instruction outside these formats gives takenOut = 0, targetAddr = insnAddr + 2, linkWrEn = 0 and swiOut = 0.
- R11: modeOut is 1 for every instruction except a register jump whose rmValue bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insnWord | input | 16 | Current instruction |
| insnAddr | input | 32 | Address of the current instruction |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| rmValue | input | 32 | Value of the register chosen by rmSel |
| linkValue | input | 32 | Current link-register contents |
| rmSel | output | 4 | Register index for register jumps |
| takenOut | output | 1 | Branch taken |
| targetAddr | output | 32 | Next fetch address |
| linkWrEn | output | 1 | Link-register write strobe |
| linkWrData | output | 32 | Value to write to the link register |
| modeOut | output | 1 | Next mode: 1 compressed, 0 full-width |
| swiOut | output | 1 | Software-interrupt encoding decoded |

## Verification
The alignment assertions assume that insnAddr is halfword aligned, as a compressed-mode fetch address always is. The bench therefore clears bit 0 of every address it drives, including the random ones. The return-address assertion assumes that every linking form other than the first call half stores the sequential address, and the stimulus covers each form under that rule. Link values and register values may be odd or unaligned, because the block itself masks the low bits of those targets.

// File: rtl/btu_pkg.sv
package btu_pkg;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } ccode_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic taken;      // transfer happens this cycle
    logic selCond;    // target from short conditional offset
    logic selUncond;  // target from medium offset
    logic selLongLo;  // target from link + low offset
    logic selExch;    // target from register
    logic linkPartial;// write partial long-call target
    logic linkReturn; // write return address
    logic swi;        // software-interrupt encoding
  } btu_ctrl_t;

  function automatic logic condHolds(input ccode_e code, input logic n, input logic z,
                                     input logic c, input logic v);
    logic r;
    unique case (code)
      CC_EQ: r = z;
      CC_NE: r = !z;
      CC_HS: r = c;
      CC_LO: r = !c;
      CC_MI: r = n;
      CC_PL: r = !n;
      CC_VS: r = v;
      CC_VC: r = !v;
      CC_HI: r = c && !z;
      CC_LS: r = !c || z;
      CC_GE: r = (n == v);
      CC_LT: r = (n != v);
      CC_GT: r = !z && (n == v);
      CC_LE: r = z || (n != v);
      default: r = 1'b0;  // AL and NV are not branch conditions here
    endcase
    return r;
  endfunction

endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
#(
  parameter int INSN_W = 16
) (
  input  logic [INSN_W-1:0] insnWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output btu_ctrl_t         ctrl
);

  localparam logic [3:0] COND_TAG  = 4'b1101;
  localparam logic [4:0] UNC_TAG   = 5'b11100;
  localparam logic [3:0] LONG_TAG  = 4'b1111;
  localparam logic [7:0] EXCH_TAG  = 8'b0100_0111;

  logic   isCondFmt, isUncFmt, isLongFmt, isExchFmt;
  logic   condUsable, condPass;
  ccode_e code;

  always_comb begin
    code       = ccode_e'(insnWord[11:8]);
    isCondFmt  = (insnWord[15:12] == COND_TAG);
    isUncFmt   = (insnWord[15:11] == UNC_TAG);
    isLongFmt  = (insnWord[15:12] == LONG_TAG);
    isExchFmt  = (insnWord[15:8] == EXCH_TAG) && (insnWord[2:0] == 3'b000);
    condUsable = isCondFmt && (code != CC_AL) && (code != CC_NV);
    condPass   = condHolds(code, flagN, flagZ, flagC, flagV);
  end

  always_comb begin
    ctrl             = '0;
    ctrl.selCond     = condUsable;
    ctrl.selUncond   = isUncFmt;
    ctrl.selLongLo   = isLongFmt && insnWord[11];
    ctrl.selExch     = isExchFmt;
    ctrl.linkPartial = isLongFmt && !insnWord[11];
    ctrl.linkReturn  = (isLongFmt && insnWord[11]) || (isExchFmt && insnWord[7]);
    ctrl.swi         = isCondFmt && (code == CC_NV);
    ctrl.taken       = (condUsable && condPass) || isUncFmt ||
                       (isLongFmt && insnWord[11]) || isExchFmt;
  end

endmodule

// File: rtl/btu_ofs.sv
module btu_ofs #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int SHIFT  = 1,
  parameter bit SIGNED = 1'b1
) (
  input  logic [OFF_W-1:0]  offIn,
  output logic [ADDR_W-1:0] offOut
);

  localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

  generate
    if (SIGNED) begin : g_sext
      assign offOut = {{EXT_W{offIn[OFF_W-1]}}, offIn, {SHIFT{1'b0}}};
    end else begin : g_zext
      assign offOut = {{EXT_W{1'b0}}, offIn, {SHIFT{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/btu_datapath.sv
module btu_datapath
  import btu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int COND_OFF_W  = 8,
  parameter int WIDE_OFF_W  = 11,
  parameter int LONG_HI_SH  = 12
) (
  input  logic [COND_OFF_W-1:0] condOff,
  input  logic [WIDE_OFF_W-1:0] wideOff,
  input  logic [ADDR_W-1:0]     insnAddr,
  input  logic [ADDR_W-1:0]     rmValue,
  input  logic [ADDR_W-1:0]     linkValue,
  input  btu_ctrl_t             ctrl,
  output logic [ADDR_W-1:0]     targetAddr,
  output logic [ADDR_W-1:0]     linkWrData,
  output logic                  modeOut
);

  localparam logic [ADDR_W-1:0] PC_AHEAD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HALF_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] condExt, uncExt, hiExt, loExt;
  logic [ADDR_W-1:0] pcVal, seqAddr, returnAddr;
  logic [ADDR_W-1:0] condTgt, uncTgt, longTgt, exchTgt, branchTgt;

  btu_ofs #(.ADDR_W(ADDR_W), .OFF_W(COND_OFF_W), .SHIFT(1), .SIGNED(1'b1))
    u_condExt (.offIn(condOff), .offOut(condExt));
  btu_ofs #(.ADDR_W(ADDR_W), .OFF_W(WIDE_OFF_W), .SHIFT(1), .SIGNED(1'b1))
    u_uncExt (.offIn(wideOff), .offOut(uncExt));
  btu_ofs #(.ADDR_W(ADDR_W), .OFF_W(WIDE_OFF_W), .SHIFT(LONG_HI_SH), .SIGNED(1'b1))
    u_hiExt (.offIn(wideOff), .offOut(hiExt));
  btu_ofs #(.ADDR_W(ADDR_W), .OFF_W(WIDE_OFF_W), .SHIFT(1), .SIGNED(1'b0))
    u_loExt (.offIn(wideOff), .offOut(loExt));

  always_comb begin
    pcVal      = insnAddr + PC_AHEAD;
    seqAddr    = insnAddr + STEP;
    returnAddr = seqAddr | ADDR_W'(1);
    condTgt    = pcVal + condExt;
    uncTgt     = pcVal + uncExt;
    longTgt    = (linkValue + loExt) & HALF_MASK;
    exchTgt    = rmValue & (rmValue[0] ? HALF_MASK : WORD_MASK);
  end

  always_comb begin
    unique case (1'b1)
      ctrl.selCond:   branchTgt = condTgt;
      ctrl.selUncond: branchTgt = uncTgt;
      ctrl.selLongLo: branchTgt = longTgt;
      ctrl.selExch:   branchTgt = exchTgt;
      default:        branchTgt = seqAddr;
    endcase
    targetAddr = ctrl.taken ? branchTgt : seqAddr;
    linkWrData = ctrl.linkPartial ? (pcVal + hiExt) : returnAddr;
    modeOut    = ctrl.selExch ? rmValue[0] : 1'b1;
  end

endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       insnWord,
  input  logic [ADDR_W-1:0] insnAddr,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic [ADDR_W-1:0] rmValue,
  input  logic [ADDR_W-1:0] linkValue,
  output logic [3:0]        rmSel,
  output logic              takenOut,
  output logic [ADDR_W-1:0] targetAddr,
  output logic              linkWrEn,
  output logic [ADDR_W-1:0] linkWrData,
  output logic              modeOut,
  output logic              swiOut
);

  localparam int INSN_W     = 16;
  localparam int COND_OFF_W = 8;
  localparam int WIDE_OFF_W = 11;

  btu_ctrl_t ctrl;

  btu_decode #(.INSN_W(INSN_W)) u_decode (
    .insnWord (insnWord),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV),
    .ctrl     (ctrl)
  );

  btu_datapath #(
    .ADDR_W     (ADDR_W),
    .COND_OFF_W (COND_OFF_W),
    .WIDE_OFF_W (WIDE_OFF_W),
    .LONG_HI_SH (12)
  ) u_datapath (
    .condOff    (insnWord[COND_OFF_W-1:0]),
    .wideOff    (insnWord[WIDE_OFF_W-1:0]),
    .insnAddr   (insnAddr),
    .rmValue    (rmValue),
    .linkValue  (linkValue),
    .ctrl       (ctrl),
    .targetAddr (targetAddr),
    .linkWrData (linkWrData),
    .modeOut    (modeOut)
  );

  assign rmSel    = insnWord[6:3];
  assign takenOut = ctrl.taken;
  assign linkWrEn = ctrl.linkPartial | ctrl.linkReturn;
  assign swiOut   = ctrl.swi;

endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int ADDR_W = 32
) (
  input logic [15:0]       insnWord,
  input logic [ADDR_W-1:0] insnAddr,
  input logic              takenOut,
  input logic [ADDR_W-1:0] targetAddr,
  input logic              linkWrEn,
  input logic [ADDR_W-1:0] linkWrData,
  input logic              modeOut,
  input logic              swiOut
);

  always_comb begin
    if (!takenOut)
      AST_FALL_THROUGH: assert (targetAddr == insnAddr + ADDR_W'(2)); // R3
    if (swiOut)
      AST_SWI_INERT: assert (!takenOut && !linkWrEn); // R9
    if (linkWrEn && insnWord[15:11] != 5'b11110)
      AST_RETURN_MARK: assert (linkWrData == ((insnAddr + ADDR_W'(2)) | ADDR_W'(1))); // R8
    if (!modeOut)
      AST_FULL_ALIGN: assert (takenOut && targetAddr[1:0] == 2'b00); // R7
    if (takenOut && modeOut && !insnAddr[0])
      AST_HALF_ALIGN: assert (!targetAddr[0]); // R1
    if (insnWord[15:11] == 5'b11100)
      AST_UNCOND_TAKEN: assert (takenOut && !linkWrEn); // R4
    if (insnWord[15:11] == 5'b11110)
      AST_PARTIAL_NOT_TAKEN: assert (!takenOut && linkWrEn); // R5
  end

endmodule

bind branch_target_unit btu_checker #(.ADDR_W(ADDR_W)) u_btuChecker (
  .insnWord   (insnWord),
  .insnAddr   (insnAddr),
  .takenOut   (takenOut),
  .targetAddr (targetAddr),
  .linkWrEn   (linkWrEn),
  .linkWrData (linkWrData),
  .modeOut    (modeOut),
  .swiOut     (swiOut)
);

// File: tb/branch_target_unit_bench.sv
module branch_target_unit_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [15:0] insnWord;
  logic [31:0] insnAddr, rmValue, linkValue;
  logic        flagN, flagZ, flagC, flagV;
  logic [3:0]  rmSel;
  logic        takenOut, linkWrEn, modeOut, swiOut;
  logic [31:0] targetAddr, linkWrData;

  branch_target_unit u_branch_target_unit (
    .insnWord, .insnAddr, .flagN, .flagZ, .flagC, .flagV, .rmValue, .linkValue,
    .rmSel, .takenOut, .targetAddr, .linkWrEn, .linkWrData, .modeOut, .swiOut
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] i, input logic [31:0] a, input logic [3:0] nzcv,
                       input logic [31:0] rv, input logic [31:0] lv);
    @(negedge clk);
    insnWord = i; insnAddr = a; rmValue = rv; linkValue = lv;
    {flagN, flagZ, flagC, flagV} = nzcv;
    @(posedge clk);
    #1;
  endtask

  function automatic logic refCond(input int code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      0: return z;            1: return !z;
      2: return c;            3: return !c;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return c & ~z;       9: return ~c | z;
      10: return n ~^ v;      11: return n ^ v;
      12: return ~z & (n ~^ v);
      13: return z | (n ^ v);
      default: return 1'b0;
    endcase
  endfunction

  typedef struct packed {
    logic [23:0] tag;
    logic [15:0] insn;
    logic [31:0] addr;
    logic [3:0]  nzcv;
    logic [31:0] rv;
    logic [31:0] lv;
    logic        eTaken;
    logic [31:0] eTarget;
    logic        eLinkEn;
    logic [31:0] eLink;
    logic        eMode;
    logic        eSwi;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R1", 16'hD005, 32'h0000_1000, 4'b0100, 32'h0, 32'h0, 1'b1, 32'h0000_100E, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R1", 16'hD1FC, 32'h0000_2000, 4'b0000, 32'h0, 32'h0, 1'b1, 32'h0000_1FFC, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R3", 16'hD005, 32'h0000_1000, 4'b0000, 32'h0, 32'h0, 1'b0, 32'h0000_1002, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R4", 16'hE3FF, 32'h0000_4000, 4'b0000, 32'h0, 32'h0, 1'b1, 32'h0000_4802, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R4", 16'hE400, 32'h0000_4000, 4'b1111, 32'h0, 32'h0, 1'b1, 32'h0000_3804, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R4", 16'hE3FF, 32'hFFFF_FFF0, 4'b0000, 32'h0, 32'h0, 1'b1, 32'h0000_07F2, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R5", 16'hF001, 32'h0000_8000, 4'b0000, 32'h0, 32'h0, 1'b0, 32'h0000_8002, 1'b1, 32'h0000_9004, 1'b1, 1'b0},
    '{"R5", 16'hF7FF, 32'h0000_8000, 4'b0000, 32'h0, 32'h0, 1'b0, 32'h0000_8002, 1'b1, 32'h0000_7004, 1'b1, 1'b0},
    '{"R6", 16'hF810, 32'h0000_8002, 4'b0000, 32'h0, 32'h0000_9004, 1'b1, 32'h0000_9024, 1'b1, 32'h0000_8005, 1'b1, 1'b0},
    '{"R6", 16'hF3FF, 32'h0010_0000, 4'b0000, 32'h0, 32'h0, 1'b0, 32'h0010_0002, 1'b1, 32'h004F_F004, 1'b1, 1'b0},
    '{"R6", 16'hFFFF, 32'h0010_0002, 4'b0000, 32'h0, 32'h004F_F004, 1'b1, 32'h0050_0002, 1'b1, 32'h0010_0005, 1'b1, 1'b0},
    '{"R6", 16'hF400, 32'h0050_0000, 4'b0000, 32'h0, 32'h0, 1'b0, 32'h0050_0002, 1'b1, 32'h0010_0004, 1'b1, 1'b0},
    '{"R6", 16'hF800, 32'h0050_0002, 4'b0000, 32'h0, 32'h0010_0004, 1'b1, 32'h0010_0004, 1'b1, 32'h0050_0005, 1'b1, 1'b0},
    '{"R7", 16'h4718, 32'h0000_5000, 4'b0000, 32'h0001_2345, 32'h0, 1'b1, 32'h0001_2344, 1'b0, 32'h0, 1'b1, 1'b0},
    '{"R7", 16'h4770, 32'h0000_5000, 4'b0000, 32'h0002_0002, 32'h0, 1'b1, 32'h0002_0000, 1'b0, 32'h0, 1'b0, 1'b0},
    '{"R8", 16'h4790, 32'h0000_6000, 4'b0000, 32'h0000_3001, 32'h0, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_6003, 1'b1, 1'b0},
    '{"R8", 16'h47A8, 32'h0000_6100, 4'b0000, 32'h0000_7006, 32'h0, 1'b1, 32'h0000_7004, 1'b1, 32'h0000_6103, 1'b0, 1'b0},
    '{"R9", 16'hDF22, 32'h0000_1000, 4'b0100, 32'h0, 32'h0, 1'b0, 32'h0000_1002, 1'b0, 32'h0, 1'b1, 1'b1},
    '{"R10", 16'h4600, 32'h0000_3000, 4'b1111, 32'h0, 32'h0, 1'b0, 32'h0000_3002, 1'b0, 32'h0, 1'b1, 1'b0}
  };

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    insnWord = '0; insnAddr = '0; rmValue = '0; linkValue = '0;
    {flagN, flagZ, flagC, flagV} = '0;

    // idle state with all-zero inputs: R10
    drive(16'h0000, 32'h0, 4'b0000, 32'h0, 32'h0);
    chk("R10", "taken idle", 32'(takenOut), 32'h0);
    chk("R10", "link idle", 32'(linkWrEn), 32'h0);
    chk("R10", "swi idle", 32'(swiOut), 32'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t vv;
      string t;
      vv = VECS[k];
      t = $sformatf("%s", vv.tag);
      drive(vv.insn, vv.addr, vv.nzcv, vv.rv, vv.lv);
      chk(t, "taken", 32'(takenOut), 32'(vv.eTaken));
      chk(t, "target", targetAddr, vv.eTarget);
      chk(t, "linkEn", 32'(linkWrEn), 32'(vv.eLinkEn));
      if (vv.eLinkEn) chk(t, "linkData", linkWrData, vv.eLink);
      chk(t, "mode R11", 32'(modeOut), 32'(vv.eMode));
      chk(t, "swi", 32'(swiOut), 32'(vv.eSwi));
    end

    // R7 register index field
    drive(16'h47A8, 32'h100, 4'b0000, 32'h0, 32'h0);
    chk("R7", "rmSel", 32'(rmSel), 32'd5);
    drive(16'h4778, 32'h100, 4'b0000, 32'h1, 32'h0);
    chk("R7", "rmSel", 32'(rmSel), 32'd15);

    // R9 code 1110 is not a branch, under every flag pattern
    for (int f = 0; f < 16; f++) begin
      drive(16'hDE10, 32'h0000_2000, 4'(f), 32'h0, 32'h0);
      chk("R9", "AL taken", 32'(takenOut), 32'h0);
      chk("R9", "AL swi", 32'(swiOut), 32'h0);
      chk("R9", "AL target", targetAddr, 32'h0000_2002);
    end

    // R2 / R1 / R3: every usable condition against every flag pattern, random offsets
    for (int code = 0; code < 14; code++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0]  off;
        logic [31:0] a, expT;
        logic        pass;
        off  = 8'($urandom);
        a    = $urandom & 32'hFFFF_FFFE;
        pass = refCond(code, 4'(f));
        expT = pass ? a + 32'd4 + 32'($signed(off)) * 2 : a + 32'd2;
        drive({4'b1101, 4'(code), off}, a, 4'(f), 32'h0, 32'h0);
        chk("R2", "cond taken", 32'(takenOut), 32'(pass));
        chk(pass ? "R1" : "R3", "cond target", targetAddr, expT);
        chk("R3", "cond no link", 32'(linkWrEn), 32'h0);
      end
    end

    // R6 chained halves with random 22-bit offsets
    for (int k = 0; k < 32; k++) begin
      logic [21:0] off22;
      logic [31:0] a, partial, expT;
      off22 = 22'($urandom);
      a     = ($urandom & 32'h0FFF_FFFE) + 32'h1000_0000;
      expT  = a + 32'd4 + 32'($signed({off22, 1'b0}));
      drive({5'b11110, off22[21:11]}, a, 4'b0000, 32'h0, 32'h0);
      partial = linkWrData;
      chk("R5", "hi link en", 32'(linkWrEn), 32'h1);
      drive({5'b11111, off22[10:0]}, a + 32'd2, 4'b0000, 32'h0, partial);
      chk("R6", "chained target", targetAddr, expT);
      chk("R6", "return bit0", 32'(linkWrData[0]), 32'h1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule